// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block generates the next control-store address for a microprogrammed controller. Each cycle it reads a 4-bit sequencing opcode, a branch-address field and one already-selected status bit, all taken from the microinstruction currently being executed. From these it picks the address of the next microinstruction. The candidates are the current address plus one, the branch field, the top of an internal return stack, and zero. The chosen address is registered and drives the control store for the following cycle.

Two pieces of state sit beside the address register. The first is a four-entry return stack, which supports calls and returns. The second is a loadable loop counter with zero detection, which supports counted repeats of one microinstruction or a short body. An enable input qualifies the status bit. When that enable is low, the status bit is treated as true. A second enable forces the visible address to zero without disturbing sequencing.

Top module: `microseq_core`

## Requirements
- R1: While reset is high at a clock edge, the address register, the stack pointer and the loop counter clear to zero and both error flags read 0.
- R2: Opcode 0 (continue), and any code from 8 to 15, makes the next address the current address plus one, wrapping modulo 2^AW.
- R3: Opcode 2 (jump) makes the next address the branch field. Opcode 1 (conditional branch) does the same when cond_en_i is low or cond_i is high; otherwise it continues to the current address plus one.
- R4: Opcode 3 makes the next address zero.
- R5: Opcode 4 (call) makes the next address the branch field and pushes the current address plus one. Opcode 5 (return) makes the next address the most recently pushed value and pops it, in last-in first-out order.
- R6: The stack holds 4 entries. A call made while it is full still jumps to the branch field, but it stores nothing and leaves the pointer unchanged. It also raises ovf_o for exactly the following cycle.
- R7: A return made while the stack is empty makes the next address zero and leaves the pointer at zero. It also raises unf_o for exactly the following cycle.
- R8: Opcode 6 loads the loop counter from the branch field and continues to the current address plus one.
- R9: Opcode 7 (repeat) behaves as follows. If the loop counter is nonzero, the counter decrements and the next address is the branch field. If the counter is zero, the counter stays at zero and the next address is the current address plus one.
- R10: When oe_i is low, addr_o reads zero. The internal address, stack and counter advance exactly as they would with oe_i high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Sequencing opcode of the current microinstruction |
| ba_i | input | AW | Branch-address / counter-load field |
| cond_i | input | 1 | Selected status bit |
| cond_en_i | input | 1 | Qualifies cond_i; low means the condition is treated as true |
| oe_i | input | 1 | Address output enable |
| addr_o | output | AW | Current control-store address, zero when oe_i is low |
| ovf_o | output | 1 | One-cycle stack overflow flag |
| unf_o | output | 1 | One-cycle stack underflow flag |

## Verification
The embedded properties assume that opcode, branch field and status inputs are known and settle before the rising edge, and that they describe the microinstruction at the address presented in that cycle. They also assume reset is held across at least one edge. The bench drives every input on the falling edge from a seeded random source, using the full opcode range including unused codes, so stack overflow, underflow and counter exhaustion all arise naturally. Directed sequences add deep call nesting, an empty-stack return, a counted loop and an output-disable window.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [3:0] {
    OP_CONT  = 4'd0,
    OP_BRC   = 4'd1,
    OP_JUMP  = 4'd2,
    OP_ZERO  = 4'd3,
    OP_CALL  = 4'd4,
    OP_RETN  = 4'd5,
    OP_LDCNT = 4'd6,
    OP_LOOP  = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    SRC_INC  = 2'd0,
    SRC_BR   = 2'd1,
    SRC_TOP  = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

endpackage

// File: rtl/useq_select.sv
module useq_select
  import useq_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       cond_i,
  input  logic       cond_en_i,
  input  logic       cnt_zero_i,
  input  logic       stk_empty_i,
  input  logic       stk_full_i,
  output src_e       src_o,
  output logic       push_o,
  output logic       pop_o,
  output logic       load_o,
  output logic       dec_o
);

  logic taken;
  assign taken = !cond_en_i || cond_i;

  always_comb begin
    src_o  = SRC_INC;
    push_o = 1'b0;
    pop_o  = 1'b0;
    load_o = 1'b0;
    dec_o  = 1'b0;
    case (op_i)
      OP_BRC:   src_o = taken ? SRC_BR : SRC_INC;
      OP_JUMP:  src_o = SRC_BR;
      OP_ZERO:  src_o = SRC_ZERO;
      OP_CALL: begin
        src_o  = SRC_BR;
        push_o = 1'b1;
      end
      OP_RETN: begin
        src_o = stk_empty_i ? SRC_ZERO : SRC_TOP;
        pop_o = 1'b1;
      end
      OP_LDCNT: load_o = 1'b1;
      OP_LOOP: begin
        src_o = cnt_zero_i ? SRC_INC : SRC_BR;
        dec_o = !cnt_zero_i;
      end
      default:  src_o = SRC_INC;
    endcase
  end

  always_comb begin
    if (push_o && pop_o) $error("p_single_stack_op_r5: push and pop together");
  end

  logic unused_full;
  assign unused_full = stk_full_i;

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int AW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          unf_o
);

  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [IW-1:0]  wr_idx, rd_idx;
  logic           do_push, do_pop;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SPW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign wr_idx  = IW'(sp_q);
  assign rd_idx  = IW'(sp_q - SPW'(1));
  assign top_o   = empty_o ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= push_i && full_o;
      unf_o <= pop_i && empty_o;
      if (do_push)     sp_q <= sp_q + SPW'(1);
      else if (do_pop) sp_q <= sp_q - SPW'(1);
    end
  end

  p_sp_bound_r6: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o) |=> (ovf_o && sp_q == $past(sp_q)));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty_o) |=> (unf_o && sp_q == '0));

  p_push_grows_r5: assert property (@(posedge clk) disable iff (rst)
    (push_i && !full_o) |=> (sp_q == $past(sp_q) + SPW'(1)));

endmodule

// File: rtl/useq_loopctr.sv
module useq_loopctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] din_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load_i)          cnt_q <= din_i;
    else if (dec_i && !zero_o) cnt_q <= cnt_q - W'(1);
  end

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(din_i)));

  p_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/microseq_core.sv
module microseq_core
  import useq_pkg::*;
#(
  parameter int AW        = 8,
  parameter int STK_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] ba_i,
  input  logic          cond_i,
  input  logic          cond_en_i,
  input  logic          oe_i,
  output logic [AW-1:0] addr_o,
  output logic          ovf_o,
  output logic          unf_o
);

  logic [AW-1:0] pc_q, pc_inc, next_pc, stk_top;
  src_e          src;
  logic          push, pop, load, dec;
  logic          cnt_zero, stk_empty, stk_full;

  assign pc_inc = pc_q + AW'(1);

  useq_select u_sel (
    .op_i        (op_i),
    .cond_i      (cond_i),
    .cond_en_i   (cond_en_i),
    .cnt_zero_i  (cnt_zero),
    .stk_empty_i (stk_empty),
    .stk_full_i  (stk_full),
    .src_o       (src),
    .push_o      (push),
    .pop_o       (pop),
    .load_o      (load),
    .dec_o       (dec)
  );

  useq_stack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stk (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (pc_inc),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  useq_loopctr #(.W(AW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .dec_i  (dec),
    .din_i  (ba_i),
    .zero_o (cnt_zero)
  );

  always_comb begin
    case (src)
      SRC_BR:  next_pc = ba_i;
      SRC_TOP: next_pc = stk_top;
      SRC_ZERO: next_pc = '0;
      default: next_pc = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  assign addr_o = oe_i ? pc_q : '0;

  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2) |=> (pc_q == $past(ba_i)));

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd3) |=> (pc_q == '0));

  p_cont_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd0 || op_i >= 4'd8) |=> (pc_q == $past(pc_q) + AW'(1)));

  p_call_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd4) |=> (pc_q == $past(ba_i)));

endmodule

// File: tb/sim_microseq_core.sv
module sim_microseq_core;

  localparam int AW = 8;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op = '0;
  logic [AW-1:0] ba = '0;
  logic          cond = 1'b0, cen = 1'b0, oe = 1'b1;
  logic [AW-1:0] addr;
  logic          ovf, unf;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [AW-1:0] m_pc, m_cnt;
  logic [AW-1:0] m_stk [DEPTH];
  int            m_sp;
  logic          m_ovf, m_unf;

  always #10 clk = ~clk;

  microseq_core #(.AW(AW), .STK_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .op_i(op), .ba_i(ba), .cond_i(cond),
    .cond_en_i(cen), .oe_i(oe), .addr_o(addr), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'd1, 4'd2: return "R3";
      4'd3:       return "R4";
      4'd4, 4'd5: return "R5";
      4'd6:       return "R8";
      4'd7:       return "R9";
      default:    return "R2";
    endcase
  endfunction

  task automatic model(logic [3:0] o, logic [AW-1:0] b, logic c, logic ce);
    logic [AW-1:0] inc;
    inc = m_pc + AW'(1);
    m_ovf = 1'b0;
    m_unf = 1'b0;
    case (o)
      4'd1: m_pc = (!ce || c) ? b : inc;
      4'd2: m_pc = b;
      4'd3: m_pc = '0;
      4'd4: begin
        if (m_sp < DEPTH) begin m_stk[m_sp] = inc; m_sp++; end
        else m_ovf = 1'b1;
        m_pc = b;
      end
      4'd5: begin
        if (m_sp > 0) begin m_sp--; m_pc = m_stk[m_sp]; end
        else begin m_unf = 1'b1; m_pc = '0; end
      end
      4'd6: begin m_cnt = b; m_pc = inc; end
      4'd7: begin
        if (m_cnt != '0) begin m_cnt--; m_pc = b; end
        else m_pc = inc;
      end
      default: m_pc = inc;
    endcase
  endtask

  task automatic step(logic [3:0] o, logic [AW-1:0] b, logic c, logic ce, logic e);
    string t;
    op = o; ba = b; cond = c; cen = ce; oe = e;
    t = tag_of(o);
    model(o, b, c, ce);
    @(posedge clk);
    @(negedge clk);
    if (e) check(t, addr, m_pc);
    else   check("R10", addr, 0);
    check((o == 4'd4) ? "R6" : "R6 ovf idle", ovf, m_ovf);
    check((o == 4'd5) ? "R7" : "R7 unf idle", unf, m_unf);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_pc = '0; m_cnt = '0; m_sp = 0; m_ovf = 0; m_unf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", addr, 0);
    check("R1", ovf, 0);
    check("R1", unf, 0);

    // R2 continue and unused codes, with wrap
    step(4'd0, 8'h00, 0, 0, 1);
    step(4'd9, 8'h00, 0, 0, 1);
    step(4'd15, 8'h00, 0, 0, 1);
    step(4'd2, 8'hFF, 0, 0, 1);
    step(4'd0, 8'h11, 0, 0, 1);
    // R3 conditional branch variants
    step(4'd1, 8'h40, 0, 1, 1);
    step(4'd1, 8'h40, 1, 1, 1);
    step(4'd1, 8'h20, 0, 0, 1);
    // R4
    step(4'd3, 8'h77, 1, 1, 1);
    // R7 return on empty stack
    step(4'd5, 8'h33, 0, 0, 1);
    // R5, R6 nested calls past capacity, then unwind
    for (int i = 0; i < 5; i++) step(4'd4, AW'(8'h10 * (i + 1)), 0, 0, 1);
    for (int i = 0; i < 5; i++) step(4'd5, 8'h00, 0, 0, 1);
    // R8, R9 counted loop
    step(4'd6, 8'd3, 0, 0, 1);
    for (int i = 0; i < 5; i++) step(4'd7, 8'h50, 0, 0, 1);
    // R10 output disabled while jumping, then visible again
    step(4'd2, 8'h99, 0, 0, 0);
    step(4'd4, 8'hA0, 0, 0, 0);
    step(4'd0, 8'h00, 0, 0, 1);

    // constrained random mix over the full opcode range
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ro;
      logic [AW-1:0] rb;
      ro = 4'($urandom_range(0, 15));
      rb = (ro == 4'd6) ? AW'($urandom_range(0, 5)) : AW'($urandom);
      step(ro, rb, 1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule